// File: doc/BRIEF.md
# Two-Digit Hexadecimal Seven-Segment Multiplexer

This block shows an 8-bit value as two hexadecimal characters on a two-digit display. The display's two digits share one set of segment lines. A single slow select signal decides which digit is lit, and the same signal decides which half of the byte is decoded onto the segment lines. While the select is low, the right digit is lit and shows the low nibble. While it is high, the left digit is lit and shows the high nibble. When the select alternates a few hundred times per second, both characters appear lit at the same time.

The select can come from outside the block on `sel_clk_in`. It can also come from an internal divider that turns the fast clock into a square wave at a rate set by a parameter. Either way, the select in use is driven out on `digit_sel_out`, and that pin goes straight to the display's digit-enable input. The segment output can be combinational, or it can be held in a register on the fast clock. In the registered case, `digit_sel_out` passes through the same register, so the lit digit and the segment pattern always change together.

Top module: `hexpair_display`

## Requirements
- R1: When the select is low (right digit), `seg_out` shows the glyph of `value_in[3:0]`.
- R2: When the select is high (left digit), `seg_out` shows the glyph of `value_in[7:4]`.
- R3: Segments are active high, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. All 16 nibbles have a defined glyph, in hex: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 B=7C C=39 D=5E E=79 F=71. Outside reset, every glyph lights at least two segments.
- R4: `digit_sel_out` carries the select that picked the nibble now on `seg_out`: 0 means the right digit and 1 means the left digit.
- R5: With `PRESCALE`=1, the select toggles once every HALF = CLK_HZ/(2*REFRESH_HZ) fast clock cycles (at least 1), so each level lasts exactly HALF cycles.
- R6: With `REG_OUT`=1, `seg_out` and `digit_sel_out` update on the fast clock edge after their inputs, and they always stay aligned with each other. While `rst` is high, both outputs are 0.
- R7: With `REG_OUT`=0 and `PRESCALE`=0, `seg_out` and `digit_sel_out` follow `value_in` and `sel_clk_in` with no clock edge.
- R8: A synchronous reset restarts the divider with the select low. The first toggle after reset is released reaches `digit_sel_out` HALF+1 edges later when the output is registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for the divider and the output register |
| rst | input | 1 | Synchronous reset, active high |
| sel_clk_in | input | 1 | External slow select, used when PRESCALE=0 |
| value_in | input | 8 | Byte to display: high nibble on the left digit, low nibble on the right |
| digit_sel_out | output | 1 | Digit enable for the display (1 = left digit) |
| seg_out | output | 7 | Segment lines a..g on bits 0..6, active high |

## Verification
Some behaviours are checked by the assertions on every clock cycle:
- the divider's toggle spacing and the upper bound on how long one level lasts;
- the blank outputs that reset forces;
- the one-cycle lag of the registered select behind the raw select;
- the lower bound on lit segments.

Other behaviours only the bench's sweeps can show. Those are the choice of nibble by select level, the exact glyph for each of the 16 codes, and the restart of the divider after a reset in mid-run. The bench covers them by sweeping all 256 byte values under both select levels, in the combinational variant and in the registered, self-dividing variant.

// File: rtl/hexseg_pkg.sv
package hexseg_pkg;

    typedef logic [3:0] nibble_t;
    typedef logic [6:0] seg_t;

    typedef struct packed {
        nibble_t hi;
        nibble_t lo;
    } byte_pair_t;

    typedef enum logic {
        DIGIT_RIGHT = 1'b0,
        DIGIT_LEFT  = 1'b1
    } digit_e;

    localparam seg_t SEG_BLANK = 7'h00;

    // Half period of the refresh square wave, in fast clock cycles, never zero.
    function automatic int unsigned refresh_half(input int unsigned clk_hz,
                                                 input int unsigned rate_hz);
        int unsigned h;
        h = (rate_hz == 0) ? 1 : clk_hz / (2 * rate_hz);
        return (h < 1) ? 1 : h;
    endfunction

    // Hex glyph, bit 0 = segment a ... bit 6 = segment g, active high.
    function automatic seg_t hex_glyph(input nibble_t n);
        seg_t s;
        unique case (n)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hexseg_refresh_div.sv
module hexseg_refresh_div
    import hexseg_pkg::*;
#(
    parameter int unsigned HALF = 4
) (
    input  logic   clk,
    input  logic   rst,
    output digit_e digit_o
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] count_q;
    digit_e        digit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            digit_q <= DIGIT_RIGHT;
        end else if (count_q == LAST) begin
            count_q <= '0;
            digit_q <= (digit_q == DIGIT_RIGHT) ? DIGIT_LEFT : DIGIT_RIGHT;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    assign digit_o = digit_q;

endmodule

// File: rtl/hexseg_nibble_pick.sv
module hexseg_nibble_pick
    import hexseg_pkg::*;
(
    input  byte_pair_t pair_i,
    input  digit_e     digit_i,
    output nibble_t    nib_o
);
    always_comb begin
        unique case (digit_i)
            DIGIT_LEFT: nib_o = pair_i.hi;
            default:    nib_o = pair_i.lo;
        endcase
    end
endmodule

// File: rtl/hexseg_glyph_stage.sv
module hexseg_glyph_stage
    import hexseg_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  nibble_t nib_i,
    input  digit_e  digit_i,
    output seg_t    seg_o,
    output digit_e  digit_o
);
    seg_t glyph;
    assign glyph = hex_glyph(nib_i);

    generate
        if (REG_OUT) begin : g_reg
            seg_t   seg_q;
            digit_e digit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    seg_q   <= SEG_BLANK;
                    digit_q <= DIGIT_RIGHT;
                end else begin
                    seg_q   <= glyph;
                    digit_q <= digit_i;
                end
            end
            assign seg_o   = seg_q;
            assign digit_o = digit_q;
        end else begin : g_comb
            assign seg_o   = glyph;
            assign digit_o = digit_i;
        end
    endgenerate
endmodule

// File: rtl/hexpair_display.sv
module hexpair_display
    import hexseg_pkg::*;
#(
    parameter bit          PRESCALE   = 1'b0,
    parameter bit          REG_OUT    = 1'b1,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned REFRESH_HZ = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_clk_in,
    input  logic [7:0] value_in,
    output logic       digit_sel_out,
    output logic [6:0] seg_out
);
    localparam int unsigned HALF = refresh_half(CLK_HZ, REFRESH_HZ);

    digit_e     sel_raw;
    digit_e     sel_shown;
    byte_pair_t pair;
    nibble_t    nib;
    seg_t       seg;

    generate
        if (PRESCALE) begin : g_div
            hexseg_refresh_div #(.HALF(HALF)) u_div (
                .clk     (clk),
                .rst     (rst),
                .digit_o (sel_raw)
            );
        end else begin : g_ext
            assign sel_raw = digit_e'(sel_clk_in);
        end
    endgenerate

    assign pair = byte_pair_t'(value_in);

    hexseg_nibble_pick u_pick (
        .pair_i  (pair),
        .digit_i (sel_raw),
        .nib_o   (nib)
    );

    hexseg_glyph_stage #(.REG_OUT(REG_OUT)) u_glyph (
        .clk     (clk),
        .rst     (rst),
        .nib_i   (nib),
        .digit_i (sel_raw),
        .seg_o   (seg),
        .digit_o (sel_shown)
    );

    assign seg_out       = seg;
    assign digit_sel_out = sel_shown;

endmodule

// File: rtl/hexpair_display_chk.sv
module hexpair_display_chk #(
    parameter bit          PRESCALE = 1'b0,
    parameter bit          REG_OUT  = 1'b1,
    parameter int unsigned HALF     = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       sel_raw,
    input logic       digit_sel_out,
    input logic [6:0] seg_out
);
    // R3: every glyph lights at least two segments once reset is over
    a_r3_glyph_lit: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(seg_out) >= 2));

    generate
        if (REG_OUT) begin : g_reg_chk
            // R6: reset blanks both registered outputs
            a_r6_reset_blank: assert property (@(posedge clk)
                $past(rst) |-> (seg_out == 7'h00 && !digit_sel_out));
            // R4: shown select lags the raw select by exactly one edge
            a_r4_sel_lag: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (digit_sel_out == $past(sel_raw)));
        end
        if (PRESCALE) begin : g_div_chk
            logic [31:0] run_q;
            logic        seen_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q  <= '0;
                    seen_q <= 1'b0;
                end else if (sel_raw != seen_q) begin
                    run_q  <= 32'd1;
                    seen_q <= sel_raw;
                end else begin
                    run_q  <= run_q + 32'd1;
                end
            end
            // R5: a level never lasts longer than HALF cycles
            a_r5_level_max: assert property (@(posedge clk) disable iff (rst)
                run_q <= HALF);
            // R5: a toggle only arrives after a full HALF-cycle level
            a_r5_toggle_spacing: assert property (@(posedge clk) disable iff (rst)
                (sel_raw != seen_q) |-> (run_q == HALF));
        end
    endgenerate
endmodule

bind hexpair_display hexpair_display_chk #(
    .PRESCALE (PRESCALE),
    .REG_OUT  (REG_OUT),
    .HALF     (HALF)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sel_raw       (sel_raw),
    .digit_sel_out (digit_sel_out),
    .seg_out       (seg_out)
);

// File: tb/sim_hexpair_display.sv
module sim_hexpair_display;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;   // 16 Hz / (2 * 2 Hz)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_ext = 1'b0;
    logic [7:0] val0 = 8'h00;
    logic [7:0] val1 = 8'h00;
    logic       dsel0, dsel1;
    logic [6:0] seg0, seg1;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // registered, self-dividing variant
    hexpair_display #(.PRESCALE(1'b1), .REG_OUT(1'b1), .CLK_HZ(16), .REFRESH_HZ(2)) u0 (
        .clk(clk), .rst(rst), .sel_clk_in(1'b0), .value_in(val0),
        .digit_sel_out(dsel0), .seg_out(seg0));

    // combinational variant with an external select
    hexpair_display #(.PRESCALE(1'b0), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .sel_clk_in(sel_ext), .value_in(val1),
        .digit_sel_out(dsel1), .seg_out(seg1));

    // Expected glyph from per-segment "dark" code sets, bit 0 = a .. bit 6 = g.
    function automatic logic [6:0] exp_glyph(input logic [3:0] n);
        logic [15:0] dark [7];
        logic [6:0]  s;
        dark[0] = 16'h2812; dark[1] = 16'hD860; dark[2] = 16'hD004;
        dark[3] = 16'h8492; dark[4] = 16'h02BA; dark[5] = 16'h208E;
        dark[6] = 16'h1083;
        for (int k = 0; k < 7; k++) s[k] = ~dark[k][n];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // R5: spacing between toggles of the shown select
    int  gap = 0;
    bit  seen_first = 1'b0;
    logic last_sel = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            gap++;
            if (dsel0 != last_sel) begin
                if (seen_first) check(gap == HALF, "R5 toggle spacing", gap, HALF);
                seen_first = 1'b1;
                gap = 0;
            end
            last_sel = dsel0;
        end else begin
            gap = 0; seen_first = 1'b0; last_sel = dsel0;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [6:0] e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(seg0 == 7'h00, "R6 reset seg", seg0, 0);
        check(dsel0 == 1'b0, "R8 reset select", dsel0, 0);

        // R7 combinational sweep: no clock edge between drive and sample
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                val1 = 8'(v); sel_ext = s[0];
                #1;
                e = exp_glyph(s[0] ? val1[7:4] : val1[3:0]);
                if (s == 0) check(seg1 == e, "R1 R3 R7 low nibble", seg1, e);
                else        check(seg1 == e, "R2 R3 R7 high nibble", seg1, e);
                check(dsel1 == s[0], "R4 select out", dsel1, s);
            end
        end

        // registered sweep with the internal divider
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            val0 = 8'(v);
            @(posedge clk);
            @(negedge clk);
            e = exp_glyph(dsel0 ? val0[7:4] : val0[3:0]);
            if (dsel0) check(seg0 == e, "R2 R6 left digit", seg0, e);
            else       check(seg0 == e, "R1 R6 right digit", seg0, e);
        end
        mon_on = 1'b0;

        // R8: reset in mid-run and divider restart
        val0 = 8'h5A;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(seg0 == 7'h00, "R6 R8 mid reset seg", seg0, 0);
        check(dsel0 == 1'b0, "R8 mid reset select", dsel0, 0);
        rst = 1'b0;
        for (int k = 1; k <= HALF + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(dsel0 == (k == HALF + 1), "R8 restart timing", dsel0, (k == HALF + 1));
        end
        e = exp_glyph(4'h5);
        check(seg0 == e, "R2 R8 left after restart", seg0, e);
        finish_run();
    end
endmodule